// File: doc/BRIEF.md
# Reservation-Checked Scratch Memory

This block is a small byte-addressed memory built from 32-bit words. Next to the memory sits a single-entry exclusive monitor. A requester issues one access per cycle. Each access is a plain load, a plain store, a reserving load or a conditional store, at byte, halfword or word size. A reserving load returns the addressed data and records the address and size as held. A conditional store writes only if that hold is still in place for exactly the same address and size. It reports pass or fail on a one-bit status, so software can build an atomic read-modify-write or a simple semaphore on top of it.

Every accepted request gets a registered response one cycle later. Any conditional store, a plain store that touches the held word, or the clear input all drop the hold. Misaligned accesses are rejected with an error flag and have no side effect.

Top module: `excl_mem`

## Requirements
- R1: A request with `req_valid` high produces exactly one cycle of `rsp_valid` high on the following clock edge; a cycle without a request gives `rsp_valid` low. `rsp_rdata` is 0 for stores and errors, and `rsp_status` is 0 for everything except a failed conditional store.
- R2: Byte layout is little-endian: the byte at address A lives in lane A[1:0] of word A>>2, at bits 8*A[1:0]+7 down to 8*A[1:0].
- R3: Loads (`req_op` 00 plain, 10 reserving) return the addressed byte (`req_size` 00), halfword (01) or word (10), zero-extended to 32 bits.
- R4: A plain store (`req_op` 01) writes the low 1, 2 or 4 bytes of `req_wdata` to the addressed lanes, leaves other bytes unchanged and ignores the unused upper bits of `req_wdata`.
- R5: A reserving load records its address and size as held, replacing any earlier hold.
- R6: A conditional store (`req_op` 11) whose address and size equal the held address and size writes like a plain store and returns status 0.
- R7: A conditional store with no hold, or with a different address or size, returns status 1 and writes nothing.
- R8: Every aligned conditional store, passing or failing, leaves no hold behind.
- R9: A plain store to any byte of the word containing the held address drops the hold; a plain store to another word does not.
- R10: `clr_excl` high in a cycle drops the hold present before that edge. A conditional store in the same cycle fails. A reserving load in the same cycle still sets a new hold.
- R11: A halfword at an odd address, a word not on a 4-byte boundary, or `req_size` 11 returns `rsp_err` 1, `rsp_rdata` 0 and `rsp_status` 0. It changes neither memory nor the hold.
- R12: After reset all memory bytes read 0, there is no hold and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 reserving load, 11 conditional store |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| clr_excl | input | 1 | Drop any hold |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 32 | Zero-extended load data |
| rsp_status | output | 1 | 1 = conditional store failed |
| rsp_err | output | 1 | Misaligned or invalid size |

## Verification
A stale hold shows at the ports on the next conditional store. That store returns status 0 where 1 is due, and it leaves a byte that a later load exposes one cycle after the load is issued. A lost hold shows as a wrong status 1 together with unchanged memory. A wrong lane or extension shows in the very next load response. The bench keeps a byte-level model with its own hold and sweeps every address at every size, so each of these surfaces within two requests of its cause.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_LDX = 2'b10,
    OP_STX = 2'b11
  } op_e;

  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;

  function automatic logic is_aligned(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_B:    return 1'b1;
      SZ_H:    return ~off[0];
      SZ_W:    return (off == 2'b00);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_B:    return 4'b0001 << off;
      SZ_H:    return 4'b0011 << off;
      SZ_W:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] place(input logic [31:0] wd, input logic [1:0] off);
    return wd << {off, 3'b000};
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] word, input logic [1:0] sz,
                                          input logic [1:0] off);
    logic [31:0] sh;
    sh = word >> {off, 3'b000};
    case (sz)
      SZ_B:    return {24'h0, sh[7:0]};
      SZ_H:    return {16'h0, sh[15:0]};
      default: return word;
    endcase
  endfunction
endpackage

// File: rtl/excl_wordmem.sv
module excl_wordmem #(
  parameter int IDX_W = 4,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       wmask,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] bytes_q [WORDS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) bytes_q[w] <= 8'h00;
      end else if (we && wmask[ln]) begin
        bytes_q[idx] <= wdata[8*ln +: 8];
      end
    end

    assign rdata[8*ln +: 8] = bytes_q[idx];
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lx_set,
  input  logic              sx_try,
  input  logic              st_plain,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              sx_pass,
  output logic              hold_q
);
  logic [ADDR_W-1:0] hold_addr_q;
  logic [1:0]        hold_size_q;
  logic              held;
  logic              word_hit;

  assign held     = hold_q & ~clr;
  assign word_hit = (addr[ADDR_W-1:2] == hold_addr_q[ADDR_W-1:2]);
  assign sx_pass  = sx_try & held & (addr == hold_addr_q) & (size == hold_size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      hold_addr_q <= '0;
      hold_size_q <= 2'b00;
    end else if (lx_set) begin
      hold_q      <= 1'b1;
      hold_addr_q <= addr;
      hold_size_q <= size;
    end else if (clr || sx_try || (st_plain && word_hit)) begin
      hold_q <= 1'b0;
    end
  end

  // R8
  sx_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sx_try |=> !hold_q);
  // R5
  lx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lx_set |=> hold_q);
  // R6
  pass_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sx_pass |-> hold_q && !clr);
  // R10
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !lx_set |=> !hold_q);
endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              clr_excl,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_status,
  output logic              rsp_err
);
  import excl_pkg::*;

  op_e         op;
  logic [1:0]  off;
  logic        aligned;
  logic        acc_ok;
  logic        is_load;
  logic        lx_set;
  logic        sx_try;
  logic        st_plain;
  logic        sx_pass;
  logic        hold_q;
  logic        mem_we;
  logic [31:0] word_rd;

  assign op       = op_e'(req_op);
  assign off      = req_addr[1:0];
  assign aligned  = is_aligned(req_size, off);
  assign acc_ok   = req_valid & aligned;
  assign is_load  = (op == OP_LD) || (op == OP_LDX);
  assign lx_set   = acc_ok & (op == OP_LDX);
  assign sx_try   = acc_ok & (op == OP_STX);
  assign st_plain = acc_ok & (op == OP_ST);
  assign mem_we   = st_plain | sx_pass;

  excl_monitor #(.ADDR_W(ADDR_W)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_excl),
    .lx_set   (lx_set),
    .sx_try   (sx_try),
    .st_plain (st_plain),
    .addr     (req_addr),
    .size     (req_size),
    .sx_pass  (sx_pass),
    .hold_q   (hold_q)
  );

  excl_wordmem #(.IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .wmask (lane_mask(req_size, off)),
    .idx   (req_addr[ADDR_W-1:2]),
    .wdata (place(req_wdata, off)),
    .rdata (word_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 32'h0;
      rsp_status <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_err    <= req_valid & ~aligned;
      rsp_status <= sx_try & ~sx_pass;
      rsp_rdata  <= (acc_ok && is_load) ? extract(word_rd, req_size, off) : 32'h0;
    end
  end

  // R7
  sx_fail_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sx_try && !sx_pass |-> !mem_we);
  // R11
  misalign_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !aligned |-> !mem_we && !sx_pass && !lx_set);
  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R7
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status |-> $past(req_valid && op == OP_STX));
  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_status && rsp_rdata == 32'h0);
endmodule

// File: tb/sim_excl_mem.sv
module sim_excl_mem;
  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int NBYTES = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = 32'h0;
  logic          clr_excl = 1'b0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          rsp_status;
  logic          rsp_err;

  int checks = 0;
  int errors = 0;

  logic [7:0]    mdl [NBYTES];
  logic          mv = 1'b0;
  logic [AW-1:0] ma = '0;
  logic [1:0]    ms = 2'b00;

  always #(CLK_P/2) clk = ~clk;

  excl_mem #(.ADDR_W(AW)) u0 (.*);

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic bad(input logic [1:0] s, input int a);
    return (s == 2'd3) || (s == 2'd1 && (a % 2) != 0) || (s == 2'd2 && (a % 4) != 0);
  endfunction

  task automatic req(input string tag, input logic [1:0] op, input int a,
                     input logic [1:0] s, input logic [31:0] wd, input logic clr);
    logic [31:0] e_rd;
    logic        e_st;
    logic        e_er;
    logic        pass;
    e_rd = 0; e_st = 0; e_er = 0;
    if (clr) mv = 0;
    if (bad(s, a)) begin
      e_er = 1;
    end else begin
      case (op)
        2'b00, 2'b10: begin
          for (int k = 0; k < nbytes(s); k++) e_rd = e_rd | (32'(mdl[a+k]) << (8*k));
          if (op == 2'b10) begin mv = 1; ma = AW'(a); ms = s; end
        end
        2'b01: begin
          for (int k = 0; k < nbytes(s); k++) mdl[a+k] = wd[8*k +: 8];
          if (mv && (a / 4) == (int'(ma) / 4)) mv = 0;
        end
        default: begin
          pass = mv && (AW'(a) == ma) && (s == ms);
          e_st = !pass;
          if (pass) for (int k = 0; k < nbytes(s); k++) mdl[a+k] = wd[8*k +: 8];
          mv = 0;
        end
      endcase
    end
    req_valid = 1; req_op = op; req_size = s; req_addr = AW'(a);
    req_wdata = wd; clr_excl = clr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; clr_excl = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_rdata !== e_rd || rsp_status !== e_st || rsp_err !== e_er) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d s=%0d: got v=%b d=%h st=%b er=%b exp v=1 d=%h st=%b er=%b",
               tag, op, a, s, rsp_valid, rsp_rdata, rsp_status, rsp_err, e_rd, e_st, e_er);
    end
  endtask

  task automatic idle(input string tag, input logic clr);
    if (clr) mv = 0;
    clr_excl = clr;
    @(posedge clk);
    @(negedge clk);
    clr_excl = 0;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: got rsp_valid=%b exp 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12: got rsp_valid=%b exp 0", rsp_valid);
    end
    for (int a = 0; a < NBYTES; a += 4) req("R12", 2'b00, a, 2'd2, 32'h0, 0);
    req("R12", 2'b11, 0, 2'd2, 32'h1234_5678, 0);
    idle("R1", 0);

    // R4 R2: byte fill, upper data bits must be ignored
    for (int a = 0; a < NBYTES; a++) req("R4", 2'b01, a, 2'd0, {24'hA5A5A5, 8'(a*7+3)}, 0);
    // R3 R2 R11: every address at every size
    for (int a = 0; a < NBYTES; a++)
      for (int s = 0; s < 4; s++) req("R3", 2'b00, a, 2'(s), 32'h0, 0);
    // R4: halfword and word stores
    for (int a = 0; a < NBYTES; a += 2) req("R4", 2'b01, a, 2'd1, 32'hBEEF_0000 | 32'(a*257), 0);
    for (int a = 0; a < NBYTES; a += 4) req("R4", 2'b00, a, 2'd2, 32'h0, 0);
    for (int a = 0; a < NBYTES; a += 8) req("R4", 2'b01, a, 2'd2, 32'h0102_0304 ^ 32'(a), 0);
    for (int a = 0; a < NBYTES; a++) req("R2", 2'b00, a, 2'd0, 32'h0, 0);

    // R5 R6 R8: matched pairs at each size, then a repeat must fail
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < NBYTES; a += nbytes(2'(s))) begin
        req("R5", 2'b10, a, 2'(s), 32'h0, 0);
        req("R6", 2'b11, a, 2'(s), 32'hC0DE_0000 | 32'(a*3+s), 0);
        req("R8", 2'b11, a, 2'(s), 32'hFFFF_FFFF, 0);
        req("R6", 2'b00, a, 2'(s), 32'h0, 0);
      end

    // R7: address or size mismatch
    req("R7", 2'b10, 8, 2'd2, 32'h0, 0);
    req("R7", 2'b11, 8, 2'd1, 32'h1111_1111, 0);
    req("R7", 2'b10, 8, 2'd1, 32'h0, 0);
    req("R7", 2'b11, 10, 2'd1, 32'h2222_2222, 0);
    req("R7", 2'b00, 8, 2'd2, 32'h0, 0);
    req("R5", 2'b10, 12, 2'd2, 32'h0, 0);
    req("R5", 2'b10, 16, 2'd2, 32'h0, 0);
    req("R5", 2'b11, 12, 2'd2, 32'h3333_3333, 0);

    // R9: plain store into held word vs other word
    req("R9", 2'b10, 20, 2'd2, 32'h0, 0);
    req("R9", 2'b01, 23, 2'd0, 32'h0000_0077, 0);
    req("R9", 2'b11, 20, 2'd2, 32'h4444_4444, 0);
    req("R9", 2'b10, 20, 2'd2, 32'h0, 0);
    req("R9", 2'b01, 40, 2'd2, 32'h5555_5555, 0);
    req("R9", 2'b11, 20, 2'd2, 32'h6666_6666, 0);

    // R10: clear alone, with a conditional store, with a reserving load
    req("R10", 2'b10, 24, 2'd2, 32'h0, 0);
    idle("R10", 1);
    req("R10", 2'b11, 24, 2'd2, 32'h7777_7777, 0);
    req("R10", 2'b10, 24, 2'd2, 32'h0, 0);
    req("R10", 2'b11, 24, 2'd2, 32'h8888_8888, 1);
    req("R10", 2'b10, 28, 2'd0, 32'h0, 1);
    req("R10", 2'b11, 28, 2'd0, 32'h0000_0099, 0);
    req("R10", 2'b00, 24, 2'd2, 32'h0, 0);

    // R11: misaligned requests leave hold and memory alone
    req("R11", 2'b10, 32, 2'd2, 32'h0, 0);
    req("R11", 2'b10, 33, 2'd1, 32'h0, 0);
    req("R11", 2'b11, 34, 2'd2, 32'hAAAA_AAAA, 0);
    req("R11", 2'b01, 35, 2'd1, 32'hBBBB_BBBB, 0);
    req("R11", 2'b01, 32, 2'd3, 32'hCCCC_CCCC, 0);
    req("R11", 2'b11, 32, 2'd2, 32'hDDDD_DDDD, 0);
    req("R11", 2'b00, 32, 2'd2, 32'h0, 0);
    idle("R1", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule